// File: doc/BRIEF.md
# Branch-Aware Fetch Group Allocator

This block sits between a multi-lane instruction front end and a circular reorder buffer. Each cycle the front end presents up to `FETCH_W` instruction records on parallel lanes. A record holds an instruction pointer, a branch flag, the actual branch outcome, the predicted direction and a store flag. The block admits the longest legal prefix of those lanes. Each admitted record is written into the reorder buffer at its tail, together with a sequential instruction ID, the cycle count at admission and a mispredict marker. Store instructions also push their ID, in program order, into a separate store-order FIFO.

The length of the fetch group depends on branch results. A correctly predicted taken branch ends the group for the cycle. A mispredicted branch ends the group and also raises a sticky fetch-stall flag, which blocks all admission until the execute side pulses a branch-resolved input. Every admitted branch emits a predictor-update strobe that carries its actual outcome. Entries leave the reorder buffer in order through a head stream, and store IDs leave through a second stream.

Back-pressure on the input lanes uses a per-lane mask. `in_ready[i]` is high in the same cycle as the lane it accepts. The accepted lanes always form a prefix starting at lane 0. A producer must keep presenting any lane that was not accepted, shifted down to lane 0, on a later cycle. Free space is counted before any retirement or store pop in the same cycle. On both output streams a transfer happens on a clock edge where valid and ready are both high.

Top module: `fetch_group_alloc`

## Requirements
- R1: After reset, `rob_occ` is 0, `fetch_stall` is 0, `head_valid` and `st_valid` are 0, and the first admitted instruction gets ID 0.
- R2: At most `FETCH_W` lanes are admitted per cycle. Admission stops at the first lane whose `in_valid` bit is 0, so `in_ready` is always a prefix of `in_valid`.
- R3: Admission stops once the entries held plus the lanes admitted so far reach `ROB_DEPTH`. `rob_occ` counts the entries held and drops by one on each head transfer.
- R4: Entries leave the head in admission order, each with its own instruction pointer and an ID one above the previous one (wrapping at 2^`ID_W`). This still holds when the tail wraps past the last slot.
- R5: A branch whose actual outcome differs from its prediction is admitted, and no later lane is admitted that cycle. `fetch_stall` is 1 from the next cycle, and that entry leaves the head with `head_misp` = 1. All other entries have `head_misp` = 0.
- R6: A branch that is correctly predicted taken is admitted and ends the group for the cycle, and `fetch_stall` stays 0.
- R7: A branch that is correctly predicted not taken does not shorten the group.
- R8: While `fetch_stall` is 1, no lane is admitted. A `br_resolve` pulse clears it on the next edge, and admission resumes in the following cycle.
- R9: Each admitted store pushes its ID into the store-order FIFO in program order, and the IDs leave on `st_id`. When the FIFO has no free slot, admission stops before the next store lane. Non-store lanes are still admitted.
- R10: Every entry records the cycle counter at admission on `head_time`. Two entries admitted k cycles apart differ by k.
- R11: `pu_valid[i]` is 1 exactly for admitted branch lanes, whether mispredicted or not, and `pu_taken[i]` carries that lane's actual outcome.
- R12: `alloc_err` is raised if a write targets an occupied slot. It never rises in correct operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | FETCH_W | Lane holds an instruction |
| in_ip | input | FETCH_W*IP_W | Instruction pointer per lane, lane 0 in the low bits |
| in_branch | input | FETCH_W | Lane is a branch |
| in_taken | input | FETCH_W | Actual branch outcome per lane |
| in_pred | input | FETCH_W | Predicted direction per lane |
| in_store | input | FETCH_W | Lane writes memory |
| in_ready | output | FETCH_W | Lane admitted this cycle |
| br_resolve | input | 1 | Execute side resolved the stalling branch |
| fetch_stall | output | 1 | Sticky stall after a mispredict |
| rob_occ | output | clog2(ROB_DEPTH+1) | Entries held |
| head_valid | output | 1 | Oldest entry present |
| head_ready | input | 1 | Retire the oldest entry |
| head_ip | output | IP_W | Oldest entry instruction pointer |
| head_id | output | ID_W | Oldest entry ID |
| head_misp | output | 1 | Oldest entry was mispredicted |
| head_time | output | TIME_W | Cycle count at admission of the oldest entry |
| st_valid | output | 1 | Store-order FIFO not empty |
| st_ready | input | 1 | Pop the store-order FIFO |
| st_id | output | ID_W | Oldest store ID |
| pu_valid | output | FETCH_W | Predictor update strobe per lane |
| pu_taken | output | FETCH_W | Actual outcome for the update |
| alloc_err | output | 1 | Write into an occupied slot |

## Verification
The bench builds the block with four lanes, a reorder buffer of six entries and a store FIFO of three. Because six is not a power of two, the tail wraps through the explicit compare path, and both the full-buffer cut and the full-FIFO cut fall inside a single four-lane group. Directed scenarios cover prefix cuts from invalid lanes, capacity, taken and mispredicted branches of both polarities, the stall and resolve sequence, store ordering and admission timestamps.

// File: rtl/fga_pkg.sv
package fga_pkg;

  typedef enum logic [0:0] {
    FS_RUN  = 1'b0,
    FS_HOLD = 1'b1
  } fetch_state_t;

  // Circular index advance for any depth, power of two or not.
  function automatic int wrap_add(int base, int off, int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/fga_admit.sv
module fga_admit #(
  parameter int W     = 4,
  parameter int OCC_W = 3,
  parameter int SQC_W = 2,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     lane_vld,
  input  logic [W-1:0]     lane_br,
  input  logic [W-1:0]     lane_tk,
  input  logic [W-1:0]     lane_pr,
  input  logic [W-1:0]     lane_st,
  input  logic             stall,
  input  logic [OCC_W-1:0] rob_free,
  input  logic [SQC_W-1:0] sq_free,
  output logic [W-1:0]     take,
  output logic [CNT_W-1:0] take_cnt,
  output logic [W-1:0]     misp_mask
);

  always_comb begin
    int  cnt;
    int  scnt;
    logic halt;
    take      = '0;
    misp_mask = '0;
    cnt       = 0;
    scnt      = 0;
    halt      = stall;
    for (int i = 0; i < W; i++) begin
      if (!halt) begin
        if (!lane_vld[i]) begin
          halt = 1'b1;
        end else if (cnt >= int'(rob_free)) begin
          halt = 1'b1;
        end else if (lane_st[i] && (scnt >= int'(sq_free))) begin
          halt = 1'b1;
        end else begin
          take[i] = 1'b1;
          cnt     = cnt + 1;
          if (lane_st[i]) scnt = scnt + 1;
          if (lane_br[i]) begin
            if (lane_tk[i] != lane_pr[i]) begin
              misp_mask[i] = 1'b1;
              halt         = 1'b1;
            end else if (lane_tk[i]) begin
              halt = 1'b1;
            end
          end
        end
      end
    end
    take_cnt = CNT_W'(cnt);
  end

endmodule

// File: rtl/fga_rob.sv
module fga_rob #(
  parameter int W      = 4,
  parameter int DEPTH  = 8,
  parameter int IP_W   = 16,
  parameter int ID_W   = 8,
  parameter int TIME_W = 16,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      wr_mask,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [W*IP_W-1:0] wr_ip,
  input  logic [W-1:0]      wr_misp,
  input  logic [ID_W-1:0]   id_base,
  input  logic [TIME_W-1:0] now,
  input  logic              head_ready,
  output logic              head_valid,
  output logic [IP_W-1:0]   head_ip,
  output logic [ID_W-1:0]   head_id,
  output logic              head_misp,
  output logic [TIME_W-1:0] head_time,
  output logic [OCC_W-1:0]  occ,
  output logic              err
);
  import fga_pkg::*;

  logic [DEPTH-1:0]  vld_q;
  logic [IP_W-1:0]   ip_q   [DEPTH];
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [TIME_W-1:0] time_q [DEPTH];
  logic [DEPTH-1:0]  misp_q;
  logic [IW-1:0]     head_q, tail_q;
  logic [IW-1:0]     slot   [W];
  logic              pop;

  always_comb begin
    for (int i = 0; i < W; i++) slot[i] = IW'(wrap_add(int'(tail_q), i, DEPTH));
  end

  always_comb begin
    err = 1'b0;
    for (int i = 0; i < W; i++)
      if (wr_mask[i] && vld_q[slot[i]]) err = 1'b1;
  end

  assign head_valid = vld_q[head_q];
  assign head_ip    = ip_q[head_q];
  assign head_id    = id_q[head_q];
  assign head_misp  = misp_q[head_q];
  assign head_time  = time_q[head_q];
  assign pop        = head_valid && head_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      misp_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      occ    <= '0;
    end else begin
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= IW'(wrap_add(int'(head_q), 1, DEPTH));
      end
      for (int i = 0; i < W; i++) begin
        if (wr_mask[i]) begin
          vld_q[slot[i]]  <= 1'b1;
          misp_q[slot[i]] <= wr_misp[i];
        end
      end
      tail_q <= IW'(wrap_add(int'(tail_q), int'(wr_cnt), DEPTH));
      occ    <= occ + OCC_W'(wr_cnt) - OCC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (wr_mask[i]) begin
        ip_q[slot[i]]   <= wr_ip[i*IP_W +: IP_W];
        id_q[slot[i]]   <= id_base + ID_W'(i);
        time_q[slot[i]] <= now;
      end
    end
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)) else $error("occupancy above depth");

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) |-> (wr_mask == '0)) else $error("write into full buffer");

  assert_no_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !err) else $error("write into occupied slot");

endmodule

// File: rtl/fga_store_fifo.sv
module fga_store_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  parameter int ID_W  = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SQC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     push,
  input  logic [ID_W-1:0]  id_base,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [ID_W-1:0]  out_id,
  output logic [SQC_W-1:0] cnt
);
  import fga_pkg::*;

  logic [ID_W-1:0] mem_q [DEPTH];
  logic [IW-1:0]   head_q, tail_q;
  logic [IW-1:0]   slot [W];
  int              npush;
  logic            pop;

  always_comb begin
    npush = 0;
    for (int i = 0; i < W; i++) begin
      slot[i] = IW'(wrap_add(int'(tail_q), npush, DEPTH));
      if (push[i]) npush = npush + 1;
    end
  end

  assign out_valid = (cnt != '0);
  assign out_id    = mem_q[head_q];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt    <= '0;
    end else begin
      if (pop) head_q <= IW'(wrap_add(int'(head_q), 1, DEPTH));
      tail_q <= IW'(wrap_add(int'(tail_q), npush, DEPTH));
      cnt    <= cnt + SQC_W'(npush) - SQC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++)
      if (push[i]) mem_q[slot[i]] <= id_base + ID_W'(i);
  end

  assert_sq_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SQC_W'(DEPTH)) else $error("store FIFO overflow");

endmodule

// File: rtl/fetch_group_alloc.sv
module fetch_group_alloc #(
  parameter int FETCH_W   = 4,
  parameter int ROB_DEPTH = 8,
  parameter int SQ_DEPTH  = 4,
  parameter int IP_W      = 16,
  parameter int ID_W      = 8,
  parameter int TIME_W    = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [FETCH_W-1:0]                  in_valid,
  input  logic [FETCH_W*IP_W-1:0]             in_ip,
  input  logic [FETCH_W-1:0]                  in_branch,
  input  logic [FETCH_W-1:0]                  in_taken,
  input  logic [FETCH_W-1:0]                  in_pred,
  input  logic [FETCH_W-1:0]                  in_store,
  output logic [FETCH_W-1:0]                  in_ready,
  input  logic                                br_resolve,
  output logic                                fetch_stall,
  output logic [$clog2(ROB_DEPTH+1)-1:0]      rob_occ,
  output logic                                head_valid,
  input  logic                                head_ready,
  output logic [IP_W-1:0]                     head_ip,
  output logic [ID_W-1:0]                     head_id,
  output logic                                head_misp,
  output logic [TIME_W-1:0]                   head_time,
  output logic                                st_valid,
  input  logic                                st_ready,
  output logic [ID_W-1:0]                     st_id,
  output logic [FETCH_W-1:0]                  pu_valid,
  output logic [FETCH_W-1:0]                  pu_taken,
  output logic                                alloc_err
);
  import fga_pkg::*;

  localparam int OCC_W = $clog2(ROB_DEPTH + 1);
  localparam int SQC_W = $clog2(SQ_DEPTH + 1);
  localparam int CNT_W = $clog2(FETCH_W + 1);

  fetch_state_t       state_q;
  logic [ID_W-1:0]    next_id_q;
  logic [TIME_W-1:0]  now_q;
  logic [FETCH_W-1:0] take, misp_mask;
  logic [CNT_W-1:0]   take_cnt;
  logic [SQC_W-1:0]   sq_cnt;
  logic [OCC_W-1:0]   rob_free;
  logic [SQC_W-1:0]   sq_free;

  assign fetch_stall = (state_q == FS_HOLD);
  assign rob_free    = OCC_W'(ROB_DEPTH) - rob_occ;
  assign sq_free     = SQC_W'(SQ_DEPTH) - sq_cnt;
  assign in_ready    = take;
  assign pu_valid    = take & in_branch;
  assign pu_taken    = take & in_branch & in_taken;

  fga_admit #(.W(FETCH_W), .OCC_W(OCC_W), .SQC_W(SQC_W)) admit_i (
    .lane_vld (in_valid),
    .lane_br  (in_branch),
    .lane_tk  (in_taken),
    .lane_pr  (in_pred),
    .lane_st  (in_store),
    .stall    (fetch_stall),
    .rob_free (rob_free),
    .sq_free  (sq_free),
    .take     (take),
    .take_cnt (take_cnt),
    .misp_mask(misp_mask)
  );

  fga_rob #(.W(FETCH_W), .DEPTH(ROB_DEPTH), .IP_W(IP_W), .ID_W(ID_W), .TIME_W(TIME_W)) rob_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask   (take),
    .wr_cnt    (take_cnt),
    .wr_ip     (in_ip),
    .wr_misp   (misp_mask),
    .id_base   (next_id_q),
    .now       (now_q),
    .head_ready(head_ready),
    .head_valid(head_valid),
    .head_ip   (head_ip),
    .head_id   (head_id),
    .head_misp (head_misp),
    .head_time (head_time),
    .occ       (rob_occ),
    .err       (alloc_err)
  );

  fga_store_fifo #(.W(FETCH_W), .DEPTH(SQ_DEPTH), .ID_W(ID_W)) sq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take & in_store),
    .id_base  (next_id_q),
    .out_ready(st_ready),
    .out_valid(st_valid),
    .out_id   (st_id),
    .cnt      (sq_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= FS_RUN;
      next_id_q <= '0;
      now_q     <= '0;
    end else begin
      now_q     <= now_q + 1'b1;
      next_id_q <= next_id_q + ID_W'(take_cnt);
      if (|misp_mask)      state_q <= FS_HOLD;
      else if (br_resolve) state_q <= FS_RUN;
    end
  end

  assert_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0) else $error("admitted an empty lane");

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> (in_ready == '0)) else $error("admission during stall");

  assert_misp_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pu_valid & (in_taken ^ in_pred))) |=> fetch_stall) else $error("mispredict did not stall");

  assert_resolve_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && br_resolve) |=> !fetch_stall) else $error("resolve did not clear stall");

endmodule

// File: tb/fetch_group_alloc_tb.sv
module fetch_group_alloc_tb_top;
  localparam int W = 4, RD = 6, SD = 3, IPW = 16, IDW = 8, TW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [W-1:0] in_valid, in_branch, in_taken, in_pred, in_store, in_ready;
  logic [W*IPW-1:0] in_ip;
  logic br_resolve, fetch_stall, head_valid, head_ready, head_misp;
  logic [$clog2(RD+1)-1:0] rob_occ;
  logic [IPW-1:0] head_ip;
  logic [IDW-1:0] head_id, st_id;
  logic [TW-1:0] head_time;
  logic st_valid, st_ready, alloc_err;
  logic [W-1:0] pu_valid, pu_taken;

  fetch_group_alloc #(.FETCH_W(W), .ROB_DEPTH(RD), .SQ_DEPTH(SD), .IP_W(IPW),
                      .ID_W(IDW), .TIME_W(TW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit err_seen = 0;
  logic [IPW-1:0] q_ip[$];
  logic [IDW-1:0] q_id[$];
  bit             q_misp[$];
  logic [IDW-1:0] q_st[$];
  logic [TW-1:0]  t_seen[$];
  logic [IDW-1:0] nid = '0;

  always @(negedge clk) if (rst_n === 1'b1 && alloc_err === 1'b1) err_seen = 1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic admit(input logic [W-1:0] v, br, tk, pr, st, input logic [IPW-1:0] base,
                       input logic [W-1:0] exp_rdy, input string tag);
    @(negedge clk);
    in_valid = v; in_branch = br; in_taken = tk; in_pred = pr; in_store = st;
    for (int i = 0; i < W; i++) in_ip[i*IPW +: IPW] = base + IPW'(i);
    #1;
    chk(in_ready == exp_rdy, {tag, " lanes admitted"}, in_ready, exp_rdy);
    chk(pu_valid == (exp_rdy & br), {"R11 update strobe ", tag}, pu_valid, exp_rdy & br);
    chk(pu_taken == (exp_rdy & br & tk), {"R11 update outcome ", tag}, pu_taken, exp_rdy & br & tk);
    @(posedge clk);
    for (int i = 0; i < W; i++) begin
      if (exp_rdy[i]) begin
        q_ip.push_back(base + IPW'(i));
        q_id.push_back(nid);
        q_misp.push_back(br[i] && (tk[i] != pr[i]));
        if (st[i]) q_st.push_back(nid);
        nid = nid + 1'b1;
      end
    end
    #1 in_valid = '0;
  endtask

  task automatic drain(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      head_ready = 1'b1;
      #1;
      chk(head_valid == 1'b1, {tag, " head valid"}, head_valid, 1);
      if (q_ip.size() > 0) begin
        chk(head_ip == q_ip[0], {"R4 head ip ", tag}, head_ip, q_ip[0]);
        chk(head_id == q_id[0], {"R4 head id ", tag}, head_id, q_id[0]);
        chk(head_misp == q_misp[0], {"R5 head misp ", tag}, head_misp, q_misp[0]);
        void'(q_ip.pop_front()); void'(q_id.pop_front()); void'(q_misp.pop_front());
      end
      t_seen.push_back(head_time);
      @(posedge clk);
      #1 head_ready = 1'b0;
    end
    chk(rob_occ == q_ip.size(), {"R3 occupancy after drain ", tag}, rob_occ, q_ip.size());
  endtask

  task automatic occ_chk(string tag);
    chk(rob_occ == q_ip.size(), {"R3 occupancy ", tag}, rob_occ, q_ip.size());
  endtask

  task automatic t_reset();
    #1;
    chk(rob_occ == 0, "R1 occupancy", rob_occ, 0);
    chk(fetch_stall == 0, "R1 stall", fetch_stall, 0);
    chk(head_valid == 0, "R1 head valid", head_valid, 0);
    chk(st_valid == 0, "R1 store valid", st_valid, 0);
  endtask

  task automatic t_full_group();
    admit(4'hf, 0, 0, 0, 0, 16'h0100, 4'hf, "R2 full group");
    occ_chk("R2 after group");
    drain(4, "R1 R4 first ids");
  endtask

  task automatic t_prefix();
    admit(4'b1011, 0, 0, 0, 0, 16'h0200, 4'b0011, "R2 gap");
    drain(2, "R2 gap drain");
  endtask

  task automatic t_capacity();
    admit(4'hf, 0, 0, 0, 0, 16'h0300, 4'hf, "R3 first");
    admit(4'hf, 0, 0, 0, 0, 16'h0310, 4'b0011, "R3 fill cut");
    admit(4'b0001, 0, 0, 0, 0, 16'h0320, 4'b0000, "R3 full");
    chk(rob_occ == RD, "R3 full occupancy", rob_occ, RD);
    drain(6, "R4 tail wrap");
  endtask

  task automatic t_taken();
    admit(4'hf, 4'b0010, 4'b0010, 4'b0010, 0, 16'h0400, 4'b0011, "R6 taken ends group");
    #1 chk(fetch_stall == 0, "R6 no stall", fetch_stall, 0);
    drain(2, "R6 drain");
  endtask

  task automatic t_not_taken();
    admit(4'hf, 4'b0010, 4'b0000, 4'b0000, 0, 16'h0500, 4'hf, "R7 not-taken continues");
    drain(4, "R7 drain");
  endtask

  task automatic resolve();
    @(negedge clk);
    br_resolve = 1'b1; in_valid = 4'hf;
    #1 chk(in_ready == 0, "R8 blocked during resolve cycle", in_ready, 0);
    @(posedge clk);
    #1 br_resolve = 1'b0; in_valid = '0;
    chk(fetch_stall == 0, "R8 stall cleared", fetch_stall, 0);
  endtask

  task automatic t_mispredict();
    admit(4'hf, 4'b0010, 4'b0010, 4'b0000, 0, 16'h0600, 4'b0011, "R5 misp cut");
    #1 chk(fetch_stall == 1, "R5 stall set", fetch_stall, 1);
    admit(4'hf, 0, 0, 0, 0, 16'h0610, 4'b0000, "R8 stalled a");
    admit(4'hf, 0, 0, 0, 0, 16'h0620, 4'b0000, "R8 stalled b");
    resolve();
    admit(4'hf, 0, 0, 0, 0, 16'h0630, 4'hf, "R8 resumed");
    drain(6, "R5 misp flag");
    admit(4'hf, 4'b0001, 4'b0000, 4'b0001, 0, 16'h0700, 4'b0001, "R5 lane0 misp");
    #1 chk(fetch_stall == 1, "R5 stall set lane0", fetch_stall, 1);
    resolve();
    drain(1, "R5 lane0 drain");
  endtask

  task automatic t_stores();
    admit(4'hf, 0, 0, 0, 4'hf, 16'h0800, 4'b0111, "R9 fifo cut");
    admit(4'b0001, 0, 0, 0, 4'b0001, 16'h0810, 4'b0000, "R9 fifo full store");
    admit(4'b0001, 0, 0, 0, 4'b0000, 16'h0820, 4'b0001, "R9 plain passes");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      st_ready = 1'b1;
      #1;
      chk(st_valid == 1, "R9 store valid", st_valid, 1);
      if (q_st.size() > 0) begin
        chk(st_id == q_st[0], "R9 store order", st_id, q_st[0]);
        void'(q_st.pop_front());
      end
      @(posedge clk);
      #1 st_ready = 1'b0;
    end
    chk(st_valid == 0, "R9 store empty", st_valid, 0);
    drain(4, "R9 drain");
  endtask

  task automatic t_time();
    admit(4'b0001, 0, 0, 0, 0, 16'h0900, 4'b0001, "R10 first");
    repeat (3) @(posedge clk);
    admit(4'b0001, 0, 0, 0, 0, 16'h0910, 4'b0001, "R10 second");
    t_seen.delete();
    drain(2, "R10 drain");
    chk(t_seen[1] - t_seen[0] == TW'(4), "R10 time gap", t_seen[1] - t_seen[0], 4);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = '0; in_branch = '0; in_taken = '0; in_pred = '0;
    in_store = '0; in_ip = '0; br_resolve = 1'b0; head_ready = 1'b0; st_ready = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_full_group();
    t_prefix();
    t_capacity();
    t_taken();
    t_not_taken();
    t_mispredict();
    t_stores();
    t_time();
    chk(!err_seen, "R12 no occupied-slot write", err_seen, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule